// File: doc/BRIEF.md
# I2C Memory Slave Interface

This block is the bus-facing half of a small byte-addressed memory that sits on a two-wire I2C bus as a slave. It brings SCL and SDA into the system clock domain, finds start, repeated start and stop conditions, and compares the incoming device address with a fixed upper nibble joined to three strap inputs. It acknowledges by pulling SDA low through an open-drain enable. It drives SDA only to acknowledge or to shift out read data.

A write transaction carries a byte that loads an internal address counter, followed by data bytes. Each data byte becomes a one-cycle write strobe on the memory port. A read transaction returns bytes starting at the counter's present value. Writing only the address byte and then issuing a repeated start gives a random read. The counter steps within an 8-byte row and wraps back to the row's first byte. A busy input, raised by the storage behind the port, makes the slave withhold the acknowledge of its device address.

Top module: `i2c_mem_slave`

## Requirements
- R1: The slave acknowledges a device-address byte whose upper seven bits equal 1010 followed by the three strap bits (strap[2] most significant), so with strap 101 the write address is AAh and the read address ABh, and with strap 000 it is A0h. The acknowledge is SDA held low through the ninth SCL high phase.
- R2: After a device address that does not match, the slave gives no acknowledge and issues no memory write until the next start condition.
- R3: While busy is high when the device address completes, the slave does not acknowledge that address.
- R4: In a write transaction, the byte after the device address loads the address counter and is acknowledged. Each following data byte is acknowledged and is written with a single mem_we pulse at the counter address, after which the counter advances.
- R5: The counter advances only within its 8-byte row: from an address whose low three bits are 111 it goes to the same address with those bits cleared.
- R6: A read transaction without a preceding address byte returns the byte at the current counter value, and the counter advances after each byte sent, including the last.
- R7: Address byte, then repeated start, then read device address returns data from the address just written into the counter.
- R8: During a read, an ACK from the master after a byte makes the slave send the next byte in the row. A NACK ends the transfer with SDA released.
- R9: A stop condition returns the slave to idle with SDA released.
- R10: Under reset SDA is released, no memory strobe is active and the counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap | input | 3 | Low three device-address bits |
| busy | input | 1 | Storage busy, suppresses the device-address acknowledge |
| mem_we | output | 1 | One-cycle byte write strobe |
| mem_re | output | 1 | One-cycle byte read strobe |
| mem_addr | output | 8 | Byte address (address counter) |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_re |

## Verification
A bus edge reaches the control logic three system cycles after it appears on the pins: two synchronizer flops and one edge register. The acknowledge drive or data bit therefore changes about three cycles after an SCL fall. The bench holds each SCL phase for six or twelve cycles and samples SDA at the end of the high phase, well after any change. Memory strobes are sampled by a monitor on every rising clock edge. The memory contents and strobe counts are compared only after the stop condition.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int ADDR_W  = 8;
    localparam int STRAP_W = 3;
    localparam logic [3:0] DEV_HI = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_DEVACK,
        ST_WORD,
        ST_WORDACK,
        ST_WDATA,
        ST_WDACK,
        ST_RDATA,
        ST_RACK,
        ST_RNEXT,
        ST_SKIP
    } bus_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    function automatic logic dev_match(input logic [7:0] b,
                                       input logic [STRAP_W-1:0] pins);
        return b[7:1] == {DEV_HI, pins};
    endfunction

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] pipe;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '1;
            prev <= 1'b1;
        end else begin
            pipe <= {pipe[STAGES-2:0], din};
            prev <= pipe[STAGES-1];
        end
    end

    assign level = pipe[STAGES-1];
    assign rise  = pipe[STAGES-1] & ~prev;
    assign fall  = ~pipe[STAGES-1] & prev;
endmodule

// File: rtl/i2cm_rowctr.sv
module i2cm_rowctr #(
    parameter int AW = 8,
    parameter int RB = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (load)
            addr <= load_val;
        else if (inc)
            addr <= {addr[AW-1:RB], addr[RB-1:0] + RB'(1)};
    end

    // R5: stepping never leaves the row and moves one place within it
    assert_row_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (inc && !load) |=> (addr[AW-1:RB] == $past(addr[AW-1:RB])) &&
                           (addr[RB-1:0] == RB'($past(addr[RB-1:0]) + RB'(1))));
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import i2cm_pkg::*;
#(
    parameter int ROW_BITS    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_pull,
    input  logic [STRAP_W-1:0] strap,
    input  logic               busy,
    output logic               mem_we,
    output logic               mem_re,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata
);
    localparam int BITS = 8;

    bus_ev_t    ev;
    bus_state_t state;
    logic       scl_lvl, sda_rise, sda_fall;
    logic [3:0] bitcnt;
    logic [7:0] rx, tx;
    logic       oe, go_read, we_q, fetch_q, fetch_d1;
    logic       ev_ok, ctr_load, ctr_inc, byte_done;
    logic [ADDR_W-1:0] ctr;

    i2cm_sync #(.STAGES(SYNC_STAGES)) u_scl (
        .clk(clk), .rst(rst), .din(scl_in),
        .level(scl_lvl), .rise(ev.scl_rise), .fall(ev.scl_fall));

    i2cm_sync #(.STAGES(SYNC_STAGES)) u_sda (
        .clk(clk), .rst(rst), .din(sda_in),
        .level(ev.sda), .rise(sda_rise), .fall(sda_fall));

    assign ev.start = sda_fall & scl_lvl;
    assign ev.stop  = sda_rise & scl_lvl;
    assign ev_ok    = !ev.start && !ev.stop;
    assign byte_done = ev_ok && ev.scl_fall && (bitcnt == 4'(BITS));

    assign ctr_load = (state == ST_WORD) && byte_done;
    assign ctr_inc  = ev_ok && (((state == ST_WDACK) && ev.scl_fall) ||
                                ((state == ST_RACK) && ev.scl_rise));

    i2cm_rowctr #(.AW(ADDR_W), .RB(ROW_BITS)) u_ctr (
        .clk(clk), .rst(rst), .load(ctr_load), .load_val(rx),
        .inc(ctr_inc), .addr(ctr));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            rx       <= '0;
            tx       <= '0;
            oe       <= 1'b0;
            go_read  <= 1'b0;
            we_q     <= 1'b0;
            fetch_q  <= 1'b0;
            fetch_d1 <= 1'b0;
        end else begin
            we_q     <= 1'b0;
            fetch_q  <= 1'b0;
            fetch_d1 <= fetch_q;
            if (ev.stop) begin
                state <= ST_IDLE;
                oe    <= 1'b0;
            end else if (ev.start) begin
                state  <= ST_DEVADR;
                bitcnt <= '0;
                oe     <= 1'b0;
            end else begin
                unique case (state)
                    ST_DEVADR, ST_WORD, ST_WDATA: begin
                        if (ev.scl_rise && bitcnt != 4'(BITS)) begin
                            rx     <= {rx[6:0], ev.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (byte_done) begin
                            bitcnt <= '0;
                            if (state == ST_DEVADR) begin
                                if (dev_match(rx, strap) && !busy) begin
                                    oe      <= 1'b1;
                                    go_read <= rx[0];
                                    fetch_q <= rx[0];
                                    state   <= ST_DEVACK;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else if (state == ST_WORD) begin
                                oe    <= 1'b1;
                                state <= ST_WORDACK;
                            end else begin
                                oe    <= 1'b1;
                                we_q  <= 1'b1;
                                state <= ST_WDACK;
                            end
                        end
                    end
                    ST_DEVACK: begin
                        if (ev.scl_fall) begin
                            if (go_read) begin
                                oe     <= ~tx[7];
                                bitcnt <= 4'd1;
                                state  <= ST_RDATA;
                            end else begin
                                oe    <= 1'b0;
                                state <= ST_WORD;
                            end
                        end
                    end
                    ST_WORDACK, ST_WDACK: begin
                        if (ev.scl_fall) begin
                            oe    <= 1'b0;
                            state <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (ev.scl_fall) begin
                            if (bitcnt == 4'(BITS)) begin
                                oe    <= 1'b0;
                                state <= ST_RACK;
                            end else begin
                                oe     <= ~tx[6];
                                tx     <= {tx[6:0], 1'b0};
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_rise) begin
                            if (!ev.sda) begin
                                fetch_q <= 1'b1;
                                state   <= ST_RNEXT;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    ST_RNEXT: begin
                        if (ev.scl_fall) begin
                            oe     <= ~tx[7];
                            bitcnt <= 4'd1;
                            state  <= ST_RDATA;
                        end
                    end
                    default: ;
                endcase
            end
            if (fetch_d1)
                tx <= mem_rdata;
        end
    end

    assign sda_pull  = oe;
    assign mem_we    = we_q;
    assign mem_re    = fetch_q;
    assign mem_addr  = ctr;
    assign mem_wdata = rx;

    // R9: idle or ignoring states never hold SDA low
    assert_idle_release_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE || state == ST_SKIP) |-> !sda_pull);

    // R9: a stop always lands in idle
    assert_stop_idle_R9: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (state == ST_IDLE));

    // R3: busy at address completion gives no acknowledge
    assert_busy_noack_R3: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_DEVADR) && byte_done && busy) |=> (!sda_pull && state == ST_SKIP));

    // R2: ignoring lasts until a start or a stop
    assert_skip_hold_R2: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_SKIP) && ev_ok) |=> (state == ST_SKIP));

    // R4: a memory write happens only while acknowledging a data byte
    assert_we_in_ack_R4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (state == ST_WDACK && sda_pull));

    // R4: write and read strobes never coincide
    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));
endmodule

// File: tb/tb_i2c_mem_slave.sv
module tb_i2c_mem_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 6;
    localparam int NVEC = 5;
    // {memory address, first data value, byte count}
    localparam logic [19:0] VEC [NVEC] = '{
        {8'h00, 8'h11, 4'd1},
        {8'h0D, 8'h20, 4'd3},
        {8'h1E, 8'h40, 4'd4},
        {8'hF0, 8'hA0, 4'd2},
        {8'h27, 8'h60, 4'd8}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic busy = 1'b0;
    logic sda_pull, mem_we, mem_re;
    logic [7:0] mem_addr, mem_wdata;
    logic [7:0] mem_rdata = 8'h00;
    wire  sda_bus = sda_m & ~sda_pull;

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    int errors = 0;
    int checks = 0;
    int we_cnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_mem_slave dut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_bus),
        .sda_pull(sda_pull), .strap(strap), .busy(busy),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            we_cnt <= we_cnt + 1;
        end
        if (mem_re)
            mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic clock_bit(input logic b, output logic seen);
        sda_m = b; tick(Q);
        scl = 1'b1; tick(2*Q);
        seen = sda_bus;
        scl = 1'b0; tick(2);
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic rd_byte(input bit give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            d[i] = s;
        end
        clock_bit(!give_ack, s);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] in_row(input logic [7:0] a, input int k);
        return {a[7:3], 3'(a[2:0] + 3'(k))};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] d;
        logic [7:0] ctr_exp;
        int we0;
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i) ^ 8'hC3;
            exp_mem[i] = 8'(i) ^ 8'hC3;
        end
        tick(5);
        // R10: reset state
        chk(!sda_pull && !mem_we && !mem_re, "R10", "strobes/SDA in reset",
            {sda_pull, mem_we, mem_re}, 0);
        chk(mem_addr == 8'h00, "R10", "counter in reset", mem_addr, 0);
        rst = 1'b0;
        tick(5);
        ctr_exp = 8'h00;

        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] a = VEC[v][19:12];
            logic [7:0] sd = VEC[v][11:4];
            int n = int'(VEC[v][3:0]);
            we0 = we_cnt;
            bus_start();
            wr_byte(8'hAA, ack); chk(ack, "R1", "write address ack", ack, 1);
            wr_byte(a, ack);     chk(ack, "R4", "memory address ack", ack, 1);
            for (int k = 0; k < n; k++) begin
                wr_byte(8'(sd + 8'(k)), ack);
                chk(ack, "R4", "data ack", ack, 1);
                exp_mem[in_row(a, k)] = 8'(sd + 8'(k));
            end
            bus_stop();
            chk(we_cnt - we0 == n, "R4", "write strobes", we_cnt - we0, n);
            for (int k = 0; k < n; k++)
                chk(mem[in_row(a, k)] == exp_mem[in_row(a, k)], "R5",
                    "row-wrapped store", mem[in_row(a, k)], exp_mem[in_row(a, k)]);
            bus_start();
            wr_byte(8'hAA, ack);
            wr_byte(a, ack);
            bus_start();
            wr_byte(8'hAB, ack); chk(ack, "R7", "read address ack", ack, 1);
            for (int k = 0; k < n; k++) begin
                rd_byte(k != n - 1, d);
                chk(d == exp_mem[in_row(a, k)], "R8", "sequential read", d,
                    exp_mem[in_row(a, k)]);
            end
            chk(!sda_pull, "R8", "released after NACK", sda_pull, 0);
            bus_stop();
            chk(!sda_pull, "R9", "released after stop", sda_pull, 0);
            ctr_exp = in_row(a, n);
        end

        // R6: current-address reads, counter advanced past the NACKed byte
        bus_start();
        wr_byte(8'hAB, ack);
        rd_byte(1'b0, d);
        bus_stop();
        chk(d == exp_mem[ctr_exp], "R6", "current read", d, exp_mem[ctr_exp]);
        bus_start();
        wr_byte(8'hAB, ack);
        rd_byte(1'b0, d);
        bus_stop();
        chk(d == exp_mem[in_row(ctr_exp, 1)], "R6", "current read after advance",
            d, exp_mem[in_row(ctr_exp, 1)]);

        // R2: wrong device address is ignored until a new start
        we0 = we_cnt;
        bus_start();
        wr_byte(8'hA0, ack); chk(!ack, "R2", "mismatch nack", ack, 0);
        wr_byte(8'h05, ack); chk(!ack, "R2", "ignored byte nack", ack, 0);
        wr_byte(8'h99, ack);
        bus_stop();
        chk(we_cnt == we0, "R2", "no write strobe", we_cnt - we0, 0);
        chk(mem[5] == exp_mem[5], "R2", "memory untouched", mem[5], exp_mem[5]);

        // R3: busy suppresses the address acknowledge
        busy = 1'b1;
        bus_start();
        wr_byte(8'hAA, ack); chk(!ack, "R3", "busy nack", ack, 0);
        bus_stop();
        busy = 1'b0;
        bus_start();
        wr_byte(8'hAA, ack); chk(ack, "R3", "ack after busy drops", ack, 1);
        bus_stop();

        // R1: straps select the low address bits
        strap = 3'b000;
        bus_start();
        wr_byte(8'hA0, ack); chk(ack, "R1", "strap 000 ack", ack, 1);
        wr_byte(8'h30, ack);
        wr_byte(8'h77, ack);
        bus_stop();
        chk(mem[8'h30] == 8'h77, "R1", "strap 000 write", mem[8'h30], 8'h77);
        bus_start();
        wr_byte(8'hAA, ack); chk(!ack, "R1", "old strap rejected", ack, 0);
        bus_stop();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule